// File: doc/BRIEF.md
# Lockable Translation Cache with Round-Robin Victim Selection

This block is a fully associative translation lookaside buffer with 32 slots. Each slot maps a virtual page number to a physical page number. A lookup searches every valid slot in the same cycle and returns a hit flag and the matching physical page. New translations come in through a fill port. An external walker or test stub supplies them.

Two pointers control where a fill lands. A round-robin victim pointer picks the slot for an ordinary fill. A lock pointer grows a pinned region upward from slot 0. A fill that asks to be pinned goes to the slot at the lock pointer, and the victim pointer never visits pinned slots. The top slot cannot be pinned. A pinning fill aimed at it still writes the translation, but the pin is dropped. A clear control empties the buffer and releases every pin.

The fill port is valid/ready. A fill is accepted on a rising clock edge when `fill_valid` and `fill_ready` are both high. `fill_ready` is low only in a cycle where `clear_all` is high. The source must then hold its request and present it again in a later cycle. Lookups are never back-pressured: the result reflects the state at the start of the cycle.

Top module: `lock_tlb`

## Requirements
- R1: After reset no lookup hits, and both the victim pointer and the lock pointer are at slot 0. The first ordinary fill lands in slot 0.
- R2: While `lk_valid` is high, `lk_hit` is high in the same cycle exactly when a valid slot holds `lk_vpn`, and `lk_ppn` then carries that slot's physical page. If several slots match, the lowest-numbered slot wins. While `lk_valid` is low, `lk_hit` is low.
- R3: An accepted fill with `fill_lock` low writes the slot at the victim pointer and marks it valid. The pointer then moves to the next slot, or back to the lock pointer after slot 31.
- R4: An accepted fill with `fill_lock` high, while the lock pointer is below 31, writes the slot at the lock pointer and raises the lock pointer by one. Slots below the lock pointer are never overwritten by ordinary fills.
- R5: Whenever the victim pointer would be below the lock pointer, it is raised to the lock pointer. Ordinary fills after N pins therefore start at slot N.
- R6: A pinning fill while the lock pointer is at 31 writes slot 31 without pinning it. Both pointers stay at 31, so later fills of either kind keep overwriting slot 31 only.
- R7: A cycle with `clear_all` high invalidates every slot, returns both pointers to 0 and releases all pins. Any fill presented in that cycle is not taken.
- R8: `fill_ready` equals the inverse of `clear_all`. A fill takes effect only on an edge where `fill_valid` and `fill_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | VPN_W | Virtual page of the new translation |
| fill_ppn | input | PPN_W | Physical page of the new translation |
| fill_lock | input | 1 | Pin the new translation |
| clear_all | input | 1 | Invalidate all slots and release pins |

## Verification
Both pointers are hidden, so a wrong pointer only shows up when a translation disappears too early or survives too long. A victim pointer that enters the pinned region shows as a miss on a pinned page after at most one full sweep of the unpinned slots. A lock pointer that runs past 30 shows when a second top-slot pin fails to displace the first. The bench checks lookups on every clock against a behavioural model. It also probes pages that were just evicted or pinned, so each of these faults appears within a few dozen fills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FILL  = 2'd1,
    OP_PIN   = 2'd2,
    OP_CLEAR = 2'd3
  } tlb_op_e;
endpackage

// File: rtl/tlb_ptrs.sv
module tlb_ptrs
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlb_op_e          op,
  output logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] lock_ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_nx, lock_nx;

  always_comb begin
    rr_nx   = rr_ptr;
    lock_nx = lock_ptr;
    unique case (op)
      OP_CLEAR: begin
        rr_nx   = '0;
        lock_nx = '0;
      end
      OP_PIN: begin
        if (lock_ptr != LAST) begin
          lock_nx = lock_ptr + 1'b1;
          if (rr_ptr < lock_nx) rr_nx = lock_nx;
        end
      end
      OP_FILL: begin
        rr_nx = (rr_ptr == LAST) ? lock_ptr : rr_ptr + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr   <= '0;
      lock_ptr <= '0;
    end else begin
      rr_ptr   <= rr_nx;
      lock_ptr <= lock_nx;
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [VPN_W-1:0]   key,
  output logic               match_any,
  output logic [PPN_W-1:0]   match_ppn,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0]            hit_vec;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_all;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (clr) v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q <= wr_vpn;
        ppn_q <= wr_ppn;
      end
    end

    assign valid_vec[i] = v_q;
    assign hit_vec[i]   = v_q && (vpn_q == key);
    assign ppn_all[i]   = ppn_q;
  end

  // lowest-numbered match wins
  always_comb begin
    match_any = 1'b0;
    match_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        match_any = 1'b1;
        match_ppn = ppn_all[i];
      end
    end
  end
endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_lock,
  input  logic             clear_all
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlb_op_e            op;
  logic               fill_fire;
  logic [IDX_W-1:0]   rr_ptr, lock_ptr, wr_idx;
  logic [ENTRIES-1:0] valid_vec;
  logic               cam_hit;
  logic [PPN_W-1:0]   cam_ppn;

  assign fill_ready = !clear_all;
  assign fill_fire  = fill_valid && fill_ready;

  always_comb begin
    if (clear_all)      op = OP_CLEAR;
    else if (fill_fire) op = fill_lock ? OP_PIN : OP_FILL;
    else                op = OP_IDLE;
  end

  assign wr_idx = (op == OP_PIN) ? lock_ptr : rr_ptr;

  tlb_ptrs #(.ENTRIES(ENTRIES)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .rr_ptr   (rr_ptr),
    .lock_ptr (lock_ptr)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (op == OP_CLEAR),
    .wr_en     (op == OP_FILL || op == OP_PIN),
    .wr_idx    (wr_idx),
    .wr_vpn    (fill_vpn),
    .wr_ppn    (fill_ppn),
    .key       (lk_vpn),
    .match_any (cam_hit),
    .match_ppn (cam_ppn),
    .valid_vec (valid_vec)
  );

  assign lk_hit = lk_valid && cam_hit;
  assign lk_ppn = cam_ppn;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear_all,
  input logic               fill_fire,
  input logic               fill_lock,
  input logic               fill_ready,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic [IDX_W-1:0]   rr_ptr,
  input logic [IDX_W-1:0]   lock_ptr,
  input logic [ENTRIES-1:0] valid_vec
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  a_r2_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  a_r3_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !clear_all) |=> ($countones(valid_vec) != 0));

  a_r4_pin_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && fill_lock && lock_ptr != LAST) |=> (lock_ptr == $past(lock_ptr) + 1'b1));

  a_r5_victim_above_pins: assert property (@(posedge clk) disable iff (!rst_n)
    rr_ptr >= lock_ptr);

  a_r6_top_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && fill_lock && lock_ptr == LAST) |=> (lock_ptr == LAST && rr_ptr == LAST));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (valid_vec == '0 && rr_ptr == '0 && lock_ptr == '0));

  a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready == !clear_all);
endmodule

bind lock_tlb tlb_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_all  (clear_all),
  .fill_fire  (fill_fire),
  .fill_lock  (fill_lock),
  .fill_ready (fill_ready),
  .lk_valid   (lk_valid),
  .lk_hit     (lk_hit),
  .rr_ptr     (rr_ptr),
  .lock_ptr   (lock_ptr),
  .valid_vec  (valid_vec)
);

// File: tb/tb_lock_tlb.sv
module tb_lock_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int VW = 20;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic          lk_hit;
  logic [PW-1:0] lk_ppn;
  logic          fill_valid = 1'b0;
  logic          fill_ready;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic          fill_lock = 1'b0;
  logic          clear_all = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference
  bit m_valid[N];
  int m_vpn[N];
  int m_ppn[N];
  int m_rr = 0;
  int m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_lock(fill_lock), .clear_all(clear_all)
  );

  function automatic int ppn_of(int v);
    return (v ^ 'h3C3C) & 'hFFFFF;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive, compare outputs against model, update model at the edge
  task automatic cyc(bit fv, bit fl, bit clr, int fvpn, bit lkv, int lkvpn, string tag);
    bit eh;
    int ep;
    fill_valid = fv; fill_lock = fl; clear_all = clr;
    fill_vpn = VW'(fvpn); fill_ppn = PW'(ppn_of(fvpn));
    lk_valid = lkv; lk_vpn = VW'(lkvpn);
    #1;
    eh = 0; ep = 0;
    if (lkv) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_valid[i] && m_vpn[i] == lkvpn) begin eh = 1; ep = m_ppn[i]; end
    end
    check(lk_hit == eh, {tag, " R2 hit"}, int'(lk_hit), int'(eh));
    if (eh) check(int'(lk_ppn) == ep, {tag, " R2 ppn"}, int'(lk_ppn), ep);
    check(fill_ready == !clr, {tag, " R8 ready"}, int'(fill_ready), int'(!clr));
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < N; i++) m_valid[i] = 0;
      m_rr = 0; m_lock = 0;
    end else if (fv) begin
      int idx;
      idx = fl ? m_lock : m_rr;
      m_valid[idx] = 1; m_vpn[idx] = fvpn; m_ppn[idx] = ppn_of(fvpn);
      if (fl) begin
        if (m_lock < N - 1) begin
          m_lock++;
          if (m_rr < m_lock) m_rr = m_lock;
        end
      end else begin
        m_rr = (m_rr == N - 1) ? m_lock : m_rr + 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic fill(int v, bit pin);
    cyc(1, pin, 0, v, 0, 0, "fill");
  endtask

  // requirement-derived probe, independent of the model
  task automatic probe(int v, bit exp_hit, string tag);
    fill_valid = 0; clear_all = 0; lk_valid = 1; lk_vpn = VW'(v);
    #1;
    check(lk_hit == exp_hit, tag, int'(lk_hit), int'(exp_hit));
    if (exp_hit) check(int'(lk_ppn) == ppn_of(v), {tag, " ppn"}, int'(lk_ppn), ppn_of(v));
    cyc(0, 0, 0, 0, 1, v, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, first fill goes to slot 0
    probe(100, 0, "R1 empty after reset");

    // R3: fill every slot, then wrap evicts slot 0
    for (int i = 0; i < N; i++) fill(100 + i, 0);
    for (int i = 0; i < N; i++) probe(100 + i, 1, "R3 filled slot");
    cyc(0, 0, 0, 0, 0, 100, "R2 lookup idle");
    fill(500, 0);
    probe(100, 0, "R1 R3 wrap evicts slot 0");
    probe(101, 1, "R3 slot 1 kept");
    probe(500, 1, "R3 new entry");

    // R7/R8: clear wins over a fill in the same cycle
    cyc(1, 0, 1, 600, 0, 0, "R7 clear with fill");
    probe(600, 0, "R7 R8 fill during clear dropped");
    probe(500, 0, "R7 cleared");
    probe(101, 0, "R7 cleared");

    // R4/R5: pin 8, then ordinary fills start at slot 8
    for (int i = 0; i < 8; i++) fill(200 + i, 1);
    for (int i = 0; i < 24; i++) fill(300 + i, 0);
    fill(400, 0);
    probe(300, 0, "R5 first ordinary fill at slot 8 evicted");
    probe(301, 1, "R5 slot 9 kept");
    for (int j = 0; j < 30; j++) fill(410 + j, 0);
    for (int i = 0; i < 8; i++) probe(200 + i, 1, "R4 pinned survives");

    // R6: pin up to 31, then top-slot pins do not stick
    cyc(0, 0, 1, 0, 0, 0, "R7 clear");
    for (int i = 0; i < N - 1; i++) fill(700 + i, 1);
    fill(900, 1);
    probe(900, 1, "R6 top pin written");
    fill(901, 1);
    probe(900, 0, "R6 top pin not held");
    probe(901, 1, "R6 top slot rewritten");
    fill(902, 0);
    probe(901, 0, "R6 ordinary fill stays on slot 31");
    probe(902, 1, "R6 ordinary fill slot 31");
    for (int i = 0; i < N - 1; i++) probe(700 + i, 1, "R6 pins 0..30 kept");

    // R7: clear released pins, ordinary fills cycle over all slots
    cyc(0, 0, 1, 0, 0, 0, "R7 clear");
    for (int i = 0; i < N + 1; i++) fill(1000 + i, 0);
    probe(700, 0, "R7 pins released");
    probe(1000, 0, "R7 slot 0 replaceable");
    probe(1001, 1, "R7 slot 1 kept");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule